// File: doc/BRIEF.md
# SPI FIFO Level Status and Interrupt Unit

This block collects the fill state of an SPI controller's transmit and receive FIFOs (256 entries each by default) and turns it into status bits and a single interrupt line. It watches the two FIFO levels, a one-cycle receive overflow pulse, receive push and pop strobes, a periodic idle tick and the engine's busy flag. The FIFOs and the serial engine live outside the block.

Software reaches six word registers through a plain read/write port with combinational read data. One register holds two 3-bit threshold codes. One register masks the four interrupt causes. The raw and masked cause registers can be read. A write-one-to-clear register acknowledges the two sticky causes, and a status register reports the FIFO and busy flags. The transmit and receive causes follow the FIFO levels directly. The overflow and receive-timeout causes latch until software clears them.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: The threshold register (address 0) holds the transmit code in bits 5:3 and the receive code in bits 11:9, and reads back only those bits. Code 0 selects level 1. Codes 1 to 5 select 4, 8, 16, 32 and 64. Codes 6 and 7 both select 128.
- R2: Transmit cause (cause bit 3) is 1 exactly while the transmit FIFO level is less than or equal to the selected transmit threshold.
- R3: Receive cause (cause bit 2) is 1 exactly while the receive FIFO level is greater than or equal to the selected receive threshold.
- R4: An overflow pulse sets the sticky overflow cause (cause bit 0), which then holds until it is cleared.
- R5: The sticky timeout cause (cause bit 1) sets on the 32nd idle tick counted while the receive FIFO is non-empty. A receive push or pop restarts the count, and an empty receive FIFO holds the count at zero.
- R6: In the mask register (address 1, bits 3:0, same bit order as the causes) a 1 blocks that cause. The masked register (address 3) equals the raw causes ANDed with the inverted mask, and the interrupt output is the OR of the masked bits.
- R7: Writing 1 to bit 0 or bit 1 of the clear register (address 4) clears the overflow or timeout cause. Bits 2 and 3 have no effect. A set event in the same cycle wins over a clear.
- R8: The status register (address 5) reads bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full and bit 4 busy. Full means a level equal to the FIFO depth.
- R9: After reset all four mask bits are 1, both sticky causes are 0 and both threshold codes are 0, so the interrupt output is 0.
- R10: The raw cause register sits at address 2. Reads of the clear register and of unused addresses return 0, and writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Word address of the register port |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_level | input | 9 | Transmit FIFO fill level, 0 to depth |
| rx_level | input | 9 | Receive FIFO fill level, 0 to depth |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_ovf | input | 1 | Receive overflow pulse |
| idle_tick | input | 1 | One-cycle tick at the serial-clock rate |
| eng_busy | input | 1 | Serial engine busy flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the FIFO levels never exceed the configured depth. They also assume that the overflow, push, pop and tick inputs are single-cycle strobes sampled at the clock edge. The stimulus keeps within this: it applies levels only from 0 to 256, and it drives every strobe for exactly one cycle on a falling edge. The threshold sweep uses each code's exact boundary levels. The timeout sequences count ticks precisely around the 32-tick limit.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int CAUSE_OVF = 0;
   localparam int CAUSE_TO  = 1;
   localparam int CAUSE_RX  = 2;
   localparam int CAUSE_TX  = 3;
   localparam int N_CAUSE   = 4;
   localparam int N_STICKY  = 2;

   localparam logic [2:0] ADR_THR    = 3'd0;
   localparam logic [2:0] ADR_MASK   = 3'd1;
   localparam logic [2:0] ADR_RAW    = 3'd2;
   localparam logic [2:0] ADR_MASKED = 3'd3;
   localparam logic [2:0] ADR_CLR    = 3'd4;
   localparam logic [2:0] ADR_STAT   = 3'd5;

   localparam int TX_CODE_LSB = 3;
   localparam int RX_CODE_LSB = 9;
   localparam int CODE_W      = 3;
endpackage

// File: rtl/spi_irq_thr_decode.sv
module spi_irq_thr_decode #(
   parameter int LVL_W = 9
) (
   input  logic [2:0]       code,
   output logic [LVL_W-1:0] level
);
   always_comb begin
      case (code)
         3'd0:    level = LVL_W'(1);
         3'd1:    level = LVL_W'(4);
         3'd2:    level = LVL_W'(8);
         3'd3:    level = LVL_W'(16);
         3'd4:    level = LVL_W'(32);
         3'd5:    level = LVL_W'(64);
         default: level = LVL_W'(128);
      endcase
   end
endmodule

// File: rtl/spi_irq_idle_timer.sv
module spi_irq_idle_timer #(
   parameter int TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic activity,
   input  logic nonempty,
   output logic fire
);
   localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   assign fire = tick && nonempty && !activity && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!nonempty || activity || fire)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (set[i])
            q[i] <= 1'b1;
         else if (clr[i])
            q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
   parameter int DEPTH   = 256,
   parameter int TO_TICKS = 32,
   parameter int DATA_W  = 32,
   localparam int LVL_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              rx_ovf,
   input  logic              idle_tick,
   input  logic              eng_busy,
   output logic              irq
);
   import spi_irq_pkg::*;

   if (DEPTH < 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 128");
   end
   if (DATA_W < 12) begin : g_bad_width
      $error("DATA_W must hold the threshold fields");
   end
   if (TO_TICKS < 2) begin : g_bad_ticks
      $error("TO_TICKS must be at least 2");
   end

   localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

   logic [CODE_W-1:0]  tx_code_q, rx_code_q;
   logic [N_CAUSE-1:0] mask_q;
   logic [LVL_W-1:0]   tx_thr, rx_thr;
   logic [N_CAUSE-1:0] raw, masked;
   logic [N_STICKY-1:0] sticky, st_set, st_clr;
   logic               to_fire;
   logic [4:0]         status;

   spi_irq_thr_decode #(.LVL_W(LVL_W)) u_tx_thr (.code(tx_code_q), .level(tx_thr));
   spi_irq_thr_decode #(.LVL_W(LVL_W)) u_rx_thr (.code(rx_code_q), .level(rx_thr));

   spi_irq_idle_timer #(.TICKS(TO_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(idle_tick),
      .activity(rx_push || rx_pop), .nonempty(rx_level != '0),
      .fire(to_fire)
   );

   assign st_set = {to_fire, rx_ovf};
   assign st_clr = (reg_wr && reg_addr == ADR_CLR) ? reg_wdata[N_STICKY-1:0] : '0;

   spi_irq_sticky #(.N(N_STICKY)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(sticky)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code_q <= '0;
         rx_code_q <= '0;
         mask_q    <= '1;
      end else if (reg_wr) begin
         if (reg_addr == ADR_THR) begin
            tx_code_q <= reg_wdata[TX_CODE_LSB +: CODE_W];
            rx_code_q <= reg_wdata[RX_CODE_LSB +: CODE_W];
         end
         if (reg_addr == ADR_MASK)
            mask_q <= reg_wdata[N_CAUSE-1:0];
      end
   end

   always_comb begin
      raw            = '0;
      raw[CAUSE_OVF] = sticky[0];
      raw[CAUSE_TO]  = sticky[1];
      raw[CAUSE_RX]  = rx_level >= rx_thr;
      raw[CAUSE_TX]  = tx_level <= tx_thr;
   end

   assign masked = raw & ~mask_q;
   assign irq    = |masked;
   assign status = {eng_busy, rx_level == FULL, rx_level != '0,
                    tx_level != FULL, tx_level == '0};

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_THR: begin
            reg_rdata[TX_CODE_LSB +: CODE_W] = tx_code_q;
            reg_rdata[RX_CODE_LSB +: CODE_W] = rx_code_q;
         end
         ADR_MASK:   reg_rdata[N_CAUSE-1:0] = mask_q;
         ADR_RAW:    reg_rdata[N_CAUSE-1:0] = raw;
         ADR_MASKED: reg_rdata[N_CAUSE-1:0] = masked;
         ADR_STAT:   reg_rdata[4:0]         = status;
         default:    reg_rdata = '0;
      endcase
   end
endmodule

module spi_fifo_irq_unit_chk #(
   parameter int DEPTH = 256,
   parameter int LVL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_ovf,
   input logic             clr_bit0,
   input logic [LVL_W-1:0] tx_level,
   input logic [LVL_W-1:0] rx_level,
   input logic [3:0]       mask_q,
   input logic [1:0]       sticky,
   input logic [3:0]       raw,
   input logic             irq
);
   assert_ovf_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> sticky[0]);
   assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky[0] && !clr_bit0) |=> sticky[0]);
   assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bit0 && !rx_ovf) |=> !sticky[0]);
   assert_timeout_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky[1]) |-> ($past(rx_level) != '0));
   assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 4'hF) |-> !irq);
   assert_tx_empty_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |-> raw[3]);
   assert_rx_full_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == LVL_W'(DEPTH)) |-> raw[2]);
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_ovf(rx_ovf),
   .clr_bit0(reg_wr && reg_addr == 3'd4 && reg_wdata[0]),
   .tx_level(tx_level), .rx_level(rx_level), .mask_q(mask_q),
   .sticky(sticky), .raw(raw), .irq(irq)
);

// File: tb/spi_fifo_irq_unit_test.sv
module spi_fifo_irq_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [8:0]  tx_level = '0, rx_level = '0;
   logic        rx_push = 0, rx_pop = 0, rx_ovf = 0, idle_tick = 0, eng_busy = 0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_fifo_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
      .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop), .rx_ovf(rx_ovf),
      .idle_tick(idle_tick), .eng_busy(eng_busy), .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); idle_tick = 1'b1;
         @(negedge clk); idle_tick = 1'b0;
      end
   endtask

   function automatic int thr_of(input int c);
      if (c == 0) return 1;
      if (c >= 6) return 128;
      return 1 << (c + 1);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      rd(3'd0, d); chk(d, 32'h0, "R9 threshold codes");
      rd(3'd1, d); chk(d, 32'hF, "R9 mask");
      rd(3'd2, d); chk(d & 32'h3, 32'h0, "R9 sticky causes");
      chk({31'b0, irq}, 32'h0, "R9 irq");
      // R10 clear reg and unused addresses read zero
      rd(3'd4, d); chk(d, 32'h0, "R10 clear reads zero");
      rd(3'd7, d); chk(d, 32'h0, "R10 unused reads zero");
      wr(3'd2, 32'hF); wr(3'd5, 32'h1F);
      rd(3'd2, d); chk(d & 32'h3, 32'h0, "R10 raw write ignored");

      // R1 R2 R3 threshold sweep
      for (int c = 0; c < 8; c++) begin
         int t;
         t = thr_of(c);
         wr(3'd0, 32'hFFFF_F1C7 | (c << 3) | (c << 9));
         rd(3'd0, d); chk(d, (c << 3) | (c << 9), $sformatf("R1 readback code %0d", c));
         for (int k = -1; k <= 1; k++) begin
            int lv;
            lv = t + k;
            @(negedge clk);
            tx_level = 9'(lv); rx_level = 9'(lv);
            rd(3'd2, d);
            chk({31'b0, d[3]}, {31'b0, lv <= t}, $sformatf("R2 tx code %0d lvl %0d", c, lv));
            chk({31'b0, d[2]}, {31'b0, lv >= t}, $sformatf("R3 rx code %0d lvl %0d", c, lv));
         end
      end
      // independent fields: tx code 1 (4), rx code 5 (64)
      wr(3'd0, (1 << 3) | (5 << 9));
      @(negedge clk); tx_level = 9'd5; rx_level = 9'd64;
      rd(3'd2, d); chk(d & 32'hC, 32'h4, "R1 separate fields");

      // R8 status sweep
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            int tl, rl;
            tl = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 255 : 256;
            rl = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 255 : 256;
            @(negedge clk);
            tx_level = 9'(tl); rx_level = 9'(rl); eng_busy = ((a + b) % 2) == 1;
            rd(3'd5, d);
            chk(d, {27'b0, eng_busy, rl == 256, rl != 0, tl != 256, tl == 0},
                $sformatf("R8 status tx %0d rx %0d", tl, rl));
         end
      end
      eng_busy = 1'b0;

      // R4 overflow sticky
      wr(3'd0, 32'h0);
      @(negedge clk); tx_level = 9'd100; rx_level = 9'd0;
      rd(3'd2, d); chk(d, 32'h0, "R4 no cause before pulse");
      @(negedge clk); rx_ovf = 1'b1;
      @(negedge clk); rx_ovf = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, d); chk(d, 32'h1, "R4 overflow held");
      chk({31'b0, irq}, 32'h0, "R6 overflow masked");
      wr(3'd1, 32'hE);
      chk({31'b0, irq}, 32'h1, "R6 overflow unmasked irq");
      rd(3'd3, d); chk(d, 32'h1, "R6 masked reg");
      // R7 bits 2,3 of clear do nothing
      wr(3'd4, 32'hC);
      rd(3'd2, d); chk(d, 32'h1, "R7 upper clear bits ignored");
      wr(3'd4, 32'h1);
      rd(3'd2, d); chk(d, 32'h0, "R7 overflow cleared");
      chk({31'b0, irq}, 32'h0, "R7 irq drops");
      // R7 set wins over clear
      @(negedge clk);
      reg_addr = 3'd4; reg_wdata = 32'h1; reg_wr = 1'b1; rx_ovf = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; rx_ovf = 1'b0;
      rd(3'd2, d); chk(d, 32'h1, "R7 set beats clear");
      wr(3'd4, 32'h1);
      wr(3'd1, 32'hF);

      // R5 timeout
      @(negedge clk); rx_level = 9'd0;
      ticks(40);
      rd(3'd2, d); chk(d & 32'h2, 32'h0, "R5 empty fifo no timeout");
      @(negedge clk); rx_level = 9'd5;
      ticks(31);
      rd(3'd2, d); chk(d & 32'h2, 32'h0, "R5 31 ticks no timeout");
      ticks(1);
      rd(3'd2, d); chk(d & 32'h2, 32'h2, "R5 32nd tick sets timeout");
      wr(3'd4, 32'h2);
      rd(3'd2, d); chk(d & 32'h2, 32'h0, "R7 timeout cleared");
      ticks(20);
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      ticks(20);
      rd(3'd2, d); chk(d & 32'h2, 32'h0, "R5 pop restarts count");
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
      ticks(31);
      rd(3'd2, d); chk(d & 32'h2, 32'h0, "R5 push restarts count");
      ticks(1);
      rd(3'd2, d); chk(d & 32'h2, 32'h2, "R5 timeout after restart");

      // R6 mask sweep with all four causes active
      @(negedge clk); rx_ovf = 1'b1;
      @(negedge clk); rx_ovf = 1'b0;
      tx_level = 9'd0; rx_level = 9'd256;
      for (int m = 0; m < 16; m++) begin
         wr(3'd1, 32'(m));
         rd(3'd1, d); chk(d, 32'(m), $sformatf("R6 mask readback %0d", m));
         rd(3'd3, d); chk(d, 32'((~m) & 15), $sformatf("R6 masked value %0d", m));
         chk({31'b0, irq}, {31'b0, m != 15}, $sformatf("R6 irq mask %0d", m));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule